// File: doc/BRIEF.md
# Streaming Pole-Zero Canceller with Baseline Re-centring

This block removes the slow negative tail that a capacitively coupled front end leaves behind each detector pulse. It takes one signed sample per clock, qualified by a valid strobe. It keeps a running integral of the samples. In the same cycle it produces a weighted sum of the present sample and that integral. A pulse entering as a decaying exponential with an undershoot leaves as a clean step. Its height is the input amplitude scaled by the gain parameter plus one. No normalisation is applied.

Under heavy pile-up an integrator that never clears lets the baseline wander. Instead of clearing the integrator when a pulse arrives, the block keeps a tally of the negative results it produces. Each time a window of negative results has filled, it pulls the integrator back by the mean of that window. The stage can therefore run without a break on a continuous stream. The gain and the window length are compile-time parameters. Coefficient derivation, further filtering and energy estimation are handled elsewhere.

Top module: `pzc_canceller`

## Requirements
- R1: On a cycle with `sampleValid` high, the integrator takes its old value plus the sign-extended sample, unless that cycle also applies a correction (R5).
- R2: `result` is combinational. It equals GAIN_M·sample + (integrator + sample), where the integrator is the value registered before the current edge. With defaults GAIN_M = 2000, so one impulse of amplitude x gives 2001·x in its own cycle and x on each following cycle.
- R3: Samples are 12-bit two's complement. The integrator and `result` are 28-bit two's complement and wrap modulo 2^28 without saturating.
- R4: A valid cycle whose `result` is negative (bit 27 set) adds one to the negative tally and adds `result` to the negative sum.
- R5: When a negative valid result is the 16th of the current window, the window closes in that cycle. The new integrator is old + sample − ((sum + result) >>> 4), where >>> is an arithmetic shift. The tally and the sum return to zero in the same write.
- R6: Non-negative results leave the tally and the sum unchanged. After a correction, counting starts again from zero, so the next correction needs 16 more negative results.
- R7: With `sampleValid` low, the integrator, tally and sum hold their values whatever the sample input carries.
- R8: Synchronous reset `rst` clears the integrator, the tally and the sum, so a zero sample then gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Qualifies `sample` on this cycle |
| sample | input | 12 | Signed input sample |
| result | output | 28 | Signed compensated output, combinational from `sample` |

## Verification
The bound checker watches the bookkeeping on every cycle. It checks that invalid cycles freeze the integrator and the tally, that each negative valid result moves the tally up by one, that a closing window leaves the tally and the sum at zero, and that an ordinary valid cycle adds exactly the sample to the integrator. The numerical outcome of a correction is left to the bench's scenarios: the shifted mean of a window, its merging with the same-cycle sample addition, and the wrap at 2^28. These are compared against a behavioural model after an isolated negative pulse, a mixed pile-up stream, and a long run of full-scale samples that forces the integrator through its wrap.

// File: rtl/pzc_pkg.sv
package pzc_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic accEn;       // valid sample: integrator advances
    logic negHit;      // valid sample with negative result
    logic windowFull;  // this negative result closes the window
  } pzcStrobe_t;
endpackage

// File: rtl/pzc_datapath.sv
module pzc_datapath
  import pzc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 28,
  parameter int GAIN_M   = 2000,
  parameter int WIN_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  pzcStrobe_t                 strobes,
  output logic signed [RESULT_W-1:0] result,
  output logic signed [RESULT_W-1:0] accOut,
  output logic signed [RESULT_W+WIN_LOG2-1:0] sumOut
);
  localparam int SUM_W = RESULT_W + WIN_LOG2;
  localparam logic signed [RESULT_W-1:0] GAIN_K = RESULT_W'(GAIN_M);

  logic signed [RESULT_W-1:0] accReg;
  logic signed [SUM_W-1:0]    negSum;
  logic signed [RESULT_W-1:0] sampleExt;
  logic signed [RESULT_W-1:0] accPlus;
  logic signed [RESULT_W-1:0] weighted;
  logic signed [SUM_W-1:0]    sumWithResult;
  logic signed [SUM_W-1:0]    meanWide;
  logic signed [RESULT_W-1:0] correction;

  always_comb begin
    sampleExt     = RESULT_W'(sample);
    accPlus       = accReg + sampleExt;
    weighted      = sampleExt * GAIN_K;
    result        = weighted + accPlus;
    sumWithResult = negSum + SUM_W'(result);
    meanWide      = sumWithResult >>> WIN_LOG2;
    correction    = meanWide[RESULT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg <= '0;
      negSum <= '0;
    end else begin
      if (strobes.accEn) begin
        accReg <= strobes.windowFull ? (accPlus - correction) : accPlus;
      end
      if (strobes.windowFull) begin
        negSum <= '0;
      end else if (strobes.negHit) begin
        negSum <= sumWithResult;
      end
    end
  end

  assign accOut = accReg;
  assign sumOut = negSum;
endmodule

// File: rtl/pzc_control.sv
module pzc_control
  import pzc_pkg::*;
#(
  parameter int WIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic                resultNeg,
  output pzcStrobe_t          strobes,
  output logic [WIN_LOG2-1:0] negCount
);
  localparam logic [WIN_LOG2-1:0] LAST_SLOT = '1;

  logic [WIN_LOG2-1:0] countReg;

  always_comb begin
    strobes.accEn      = sampleValid;
    strobes.negHit     = sampleValid && resultNeg;
    strobes.windowFull = strobes.negHit && (countReg == LAST_SLOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countReg <= '0;
    end else if (strobes.windowFull) begin
      countReg <= '0;
    end else if (strobes.negHit) begin
      countReg <= countReg + 1'b1;
    end
  end

  assign negCount = countReg;
endmodule

// File: rtl/pzc_canceller.sv
module pzc_canceller
  import pzc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 28,
  parameter int GAIN_M   = 2000,
  parameter int WIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [RESULT_W-1:0] result
);
  localparam int SUM_W = RESULT_W + WIN_LOG2;

  pzcStrobe_t                 strobes;
  logic signed [RESULT_W-1:0] resultS;
  logic signed [RESULT_W-1:0] accVal;
  logic signed [SUM_W-1:0]    negSum;
  logic [WIN_LOG2-1:0]        negCount;

  pzc_control #(.WIN_LOG2(WIN_LOG2)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .resultNeg  (resultS[RESULT_W-1]),
    .strobes    (strobes),
    .negCount   (negCount)
  );

  pzc_datapath #(
    .SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W),
    .GAIN_M(GAIN_M), .WIN_LOG2(WIN_LOG2)
  ) uData (
    .clk    (clk),
    .rst    (rst),
    .sample ($signed(sample)),
    .strobes(strobes),
    .result (resultS),
    .accOut (accVal),
    .sumOut (negSum)
  );

  assign result = resultS;
endmodule

// File: rtl/pzc_canceller_chk.sv
module pzc_canceller_chk #(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 28,
  parameter int WIN_LOG2 = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        sampleValid,
  input logic [SAMPLE_W-1:0]         sample,
  input logic [RESULT_W-1:0]         result,
  input logic [RESULT_W-1:0]         accVal,
  input logic [RESULT_W+WIN_LOG2-1:0] negSum,
  input logic [WIN_LOG2-1:0]         negCount,
  input logic                        windowFull
);
  localparam logic [WIN_LOG2-1:0] LAST_SLOT = '1;

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(accVal) && $stable(negCount) && $stable(negSum)); // R7

  AST_TALLY_STEP: assert property (@(posedge clk) disable iff (rst)
    sampleValid && result[RESULT_W-1] && (negCount != LAST_SLOT)
    |=> negCount == $past(negCount) + 1'b1); // R4

  AST_NONNEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    sampleValid && !result[RESULT_W-1] |=> $stable(negCount) && $stable(negSum)); // R6

  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    windowFull |=> (negCount == '0) && (negSum == '0)); // R5

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    sampleValid && !windowFull
    |=> accVal == $past(accVal) + RESULT_W'($signed($past(sample)))); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (accVal == '0) && (negCount == '0) && (negSum == '0)); // R8
endmodule

bind pzc_canceller pzc_canceller_chk #(
  .SAMPLE_W(SAMPLE_W), .RESULT_W(RESULT_W), .WIN_LOG2(WIN_LOG2)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .sample     (sample),
  .result     (result),
  .accVal     (accVal),
  .negSum     (negSum),
  .negCount   (negCount),
  .windowFull (strobes.windowFull)
);

// File: tb/tb_pzc_canceller.sv
module tb_pzc_canceller;
  localparam int SAMPLE_W = 12;
  localparam int RESULT_W = 28;
  localparam int GAIN     = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sample = '0;
  logic [RESULT_W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // behavioural model state
  longint mAcc = 0;
  longint mSum = 0;
  int     mCnt = 0;

  always #5 clk = ~clk;

  pzc_canceller dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .sample(sample), .result(result)
  );

  function automatic longint wrapR(longint x);
    longint m;
    m = x & ((64'sd1 <<< RESULT_W) - 1);
    if (m >= (64'sd1 <<< (RESULT_W - 1))) m = m - (64'sd1 <<< RESULT_W);
    return m;
  endfunction

  function automatic longint gotResult();
    return longint'($signed(result));
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: result got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive, compare combinational result, advance model
  task automatic step(bit vld, int v, string tag);
    longint r;
    longint sw;
    @(negedge clk);
    sampleValid = vld;
    sample = SAMPLE_W'(v);
    #2;
    r = wrapR(longint'(v) * GAIN + mAcc + longint'(v));
    check(tag, gotResult(), r);
    if (vld) begin
      if (r < 0) begin
        if (mCnt == 15) begin
          sw = mSum + r;
          mAcc = wrapR(mAcc + v - (sw >>> 4));
          mSum = 0;
          mCnt = 0;
        end else begin
          mSum = mSum + r;
          mCnt++;
          mAcc = wrapR(mAcc + v);
        end
      end else begin
        mAcc = wrapR(mAcc + v);
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    sample = '0;
    @(negedge clk);
    rst = 1'b0;
    mAcc = 0; mSum = 0; mCnt = 0;
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R8: cleared state gives zero output
    step(1'b0, 0, "R8");
    check("R8", gotResult(), 0);

    // R2: single positive impulse
    step(1'b1, 100, "R2");
    check("R2", gotResult(), 200100);
    step(1'b1, 0, "R1");
    check("R1", gotResult(), 100);

    // R7: invalid cycles with junk samples leave the state alone
    for (int i = 0; i < 5; i++) step(1'b0, 1000 + i, "R7");
    step(1'b1, 0, "R7");
    check("R7", gotResult(), 100);

    // R4/R5: isolated negative pulse fills one window
    doReset();
    step(1'b1, -50, "R4");
    check("R4", gotResult(), -100050);
    for (int i = 0; i < 15; i++) step(1'b1, 0, "R5");
    // sum = -100800, mean -6300, integrator -50 + 6300
    step(1'b1, 0, "R5");
    check("R5", gotResult(), 6250);

    // R6: non-negative outputs do not count; restart after correction
    doReset();
    step(1'b1, -3, "R6");
    for (int i = 0; i < 14; i++) step(1'b1, 0, "R6");
    step(1'b1, 7, "R6");     // positive output, not counted
    step(1'b1, -5, "R6");    // 16th negative closes window
    step(1'b1, 0, "R6");
    for (int i = 0; i < 20; i++) step(1'b1, -1, "R6");

    // mixed pile-up stream
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int v;
      v = ($urandom % 8 == 0) ? int'($urandom % 2048) : -int'($urandom % 40);
      step(($urandom % 5) != 0, v, "R2");
    end

    // R3: sustained full-scale input forces the integrator through its wrap
    doReset();
    for (int i = 0; i < 70000; i++) step(1'b1, 2047, "R3");
    for (int i = 0; i < 200; i++) step(1'b1, -2048, "R3");

    // R8: reset in the middle of activity
    doReset();
    step(1'b1, 0, "R8");
    check("R8", gotResult(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule